// File: doc/BRIEF.md
# Recirculating Pattern Store with Interleaved Segmented Output

This block is an on-chip store for a test pattern that feeds a 6-bit converter core under test. In load mode the pattern arrives one bit at a time on a serial pin, qualified by an enable, and fills a bank of 48 shift registers, each 104 bits deep. In play mode every register is clocked on every cycle and feeds its head bit back to its tail. The stored 832-sample pattern therefore repeats indefinitely, and the switching activity does not depend on the data held.

Each internal cycle of play mode presents eight consecutive samples side by side. A downstream serializer can then run the converter at eight times the internal rate. Each sample is also given in segmented form: the three upper bits become a 7-line thermometer code and the three lower bits pass through as binary-weighted lines. Registers are indexed as lane*6 + bit, so the 48 registers form 8 lanes of 6 bits.

Top module: `pattern_shift_store`

## Requirements
- R1: After reset, load_done, out_valid, samples, therm and bin are all zero.
- R2: Accepted serial bit j (counting from 0 since reset or since the last return to load mode) is bit b of sample 8n+k of the pattern, where j = (k*6+b)*104 + n, for 0 <= n < 104, 0 <= k < 8 and 0 <= b < 6.
- R3: load_done rises right after the 4992nd accepted bit and not before, and it stays high until the block returns to load mode.
- R4: A serial bit is accepted only when mode_play is 0, ser_en is 1 and load_done is 0. Bits offered with ser_en low, after load_done, or in play mode leave the stored pattern unchanged.
- R5: One cycle after mode_play is sampled high following a complete load, out_valid is 1 and lane k (samples[k*6 +: 6]) carries sample 8n+k, where n counts the play cycles from 0.
- R6: Playback recirculates: word n+104 equals word n for as long as play mode lasts.
- R7: For each lane k and each i from 0 to 6, therm[k*7+i] is 1 exactly when the lane's upper three bits, read as a number, exceed i.
- R8: bin[k*3 +: 3] equals the lower three bits of lane k.
- R9: One cycle after mode_play is sampled low, out_valid is 0 and samples, therm and bin are all zero.
- R10: When mode_play falls, load_done clears on the same edge and the fill restarts at register 0, position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_play | input | 1 | 1 = play, 0 = load |
| ser_en | input | 1 | Qualifies ser_in for one bit in load mode |
| ser_in | input | 1 | Serial pattern data |
| load_done | output | 1 | High once the full pattern has been shifted in |
| out_valid | output | 1 | High while a played word is presented |
| samples | output | 48 | Eight 6-bit samples, lane k at bits [k*6 +: 6] |
| therm | output | 56 | Thermometer code of the upper bits, lane k at [k*7 +: 7] |
| bin | output | 24 | Lower three bits, lane k at [k*3 +: 3] |

## Verification
The bench loads random, ramp and all-ones patterns with random gaps in the enable. It then plays two full periods and compares every lane against the fill order. A wrong bit-to-register mapping, or a mismatch in the head-to-tail direction, shows up as scrambled lanes or as samples shifted by one position. The bench checks load_done one bit before the end and again at the end: an off-by-one counter either raises it early or leaves the last register short by one bit.

After the load is done, and also during play, the bench drives extra bits. A design that accepted them would corrupt the second period or the played words. The bench also drops out of play partway through a period, checks that the outputs go quiet and load_done clears, then reloads and confirms that playback restarts at sample 0 instead of at a stale phase.

// File: rtl/pattern_shift_store.sv
module pattern_shift_store #(
  parameter int LANES = 8,
  parameter int SBITS = 6,
  parameter int UBITS = 3,
  parameter int DEPTH = 104
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             mode_play,
  input  logic                             ser_en,
  input  logic                             ser_in,
  output logic                             load_done,
  output logic                             out_valid,
  output logic [LANES*SBITS-1:0]           samples,
  output logic [LANES*((1<<UBITS)-1)-1:0]  therm,
  output logic [LANES*(SBITS-UBITS)-1:0]   bin
);
  localparam int NREG = LANES * SBITS;
  localparam int TW   = (1 << UBITS) - 1;
  localparam int LB   = SBITS - UBITS;
  localparam int RW   = $clog2(NREG);
  localparam int PW   = $clog2(DEPTH);

  logic [DEPTH-1:0] sr [NREG];
  logic [RW-1:0]    reg_idx;
  logic [PW-1:0]    pos;
  logic             prev_play;
  logic [NREG-1:0]  word_q;

  wire play_fall = prev_play && !mode_play;
  wire take      = !mode_play && ser_en && !load_done && !play_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_play <= 1'b0;
      reg_idx   <= '0;
      pos       <= '0;
      load_done <= 1'b0;
    end else begin
      prev_play <= mode_play;
      if (play_fall) begin
        reg_idx   <= '0;
        pos       <= '0;
        load_done <= 1'b0;
      end else if (take) begin
        if (pos == PW'(DEPTH-1)) begin
          pos <= '0;
          if (reg_idx == RW'(NREG-1)) load_done <= 1'b1;
          else reg_idx <= reg_idx + 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    wire ld = take && (reg_idx == RW'(r));
    always_ff @(posedge clk) begin
      if (mode_play)
        sr[r] <= {sr[r][0], sr[r][DEPTH-1:1]};
      else if (ld)
        sr[r] <= {ser_in, sr[r][DEPTH-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !mode_play) begin
      word_q    <= '0;
      out_valid <= 1'b0;
    end else begin
      for (int r = 0; r < NREG; r++) word_q[r] <= sr[r][0];
      out_valid <= 1'b1;
    end
  end

  assign samples = word_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    wire [UBITS-1:0] up = word_q[k*SBITS+LB +: UBITS];
    assign bin[k*LB +: LB] = word_q[k*SBITS +: LB];
    for (genvar i = 0; i < TW; i++) begin : g_t
      assign therm[k*TW+i] = (up > UBITS'(i));
    end
  end
endmodule

module pattern_shift_store_chk #(
  parameter int LANES = 8,
  parameter int TW    = 7,
  parameter int LB    = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  mode_play,
  input logic                  load_done,
  input logic                  out_valid,
  input logic [LANES*TW-1:0]   therm,
  input logic [LANES*LB-1:0]   bin
);
  function automatic logic therm_ok(input logic [LANES*TW-1:0] t);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < LANES; k++)
      for (int i = 1; i < TW; i++)
        if (t[k*TW+i] && !t[k*TW+i-1]) ok = 1'b0;
    return ok;
  endfunction

  a_r9_quiet_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (therm == '0 && bin == '0));
  a_r7_therm_shape: assert property (@(posedge clk) disable iff (!rst_n)
    therm_ok(therm));
  a_r5_valid_in_play: assert property (@(posedge clk) disable iff (!rst_n)
    mode_play |=> out_valid);
  a_r9_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_play |=> !out_valid);
  a_r4_done_frozen_in_play: assert property (@(posedge clk) disable iff (!rst_n)
    mode_play |=> $stable(load_done));
  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && mode_play) |=> load_done);
endmodule

bind pattern_shift_store pattern_shift_store_chk #(
  .LANES(LANES), .TW((1<<UBITS)-1), .LB(SBITS-UBITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_play(mode_play), .load_done(load_done),
  .out_valid(out_valid), .therm(therm), .bin(bin)
);

// File: tb/sim_pattern_shift_store.sv
module sim_pattern_shift_store;
  localparam int NB = 48 * 104;

  logic clk = 0, rst_n = 0, mode_play = 0, ser_en = 0, ser_in = 0;
  logic load_done, out_valid;
  logic [47:0] samples;
  logic [55:0] therm;
  logic [23:0] bin;

  int total = 0, bad = 0;
  bit pat [NB];

  pattern_shift_store u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] smp(input int s);
    logic [5:0] v;
    int n = (s / 8) % 104, k = s % 8;
    for (int b = 0; b < 6; b++) v[b] = pat[(k*6+b)*104 + n];
    return v;
  endfunction

  function automatic logic [47:0] exp_word(input int n);
    logic [47:0] w;
    for (int k = 0; k < 8; k++) w[k*6 +: 6] = smp(8*(n%104) + k);
    return w;
  endfunction

  function automatic logic [55:0] exp_therm(input logic [47:0] w);
    logic [55:0] t;
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < 7; i++) t[k*7+i] = (int'(w[k*6+3 +: 3]) > i);
    return t;
  endfunction

  function automatic logic [23:0] exp_bin(input logic [47:0] w);
    logic [23:0] b;
    for (int k = 0; k < 8; k++) b[k*3 +: 3] = w[k*6 +: 3];
    return b;
  endfunction

  task automatic make_pat(input int kind);
    for (int s = 0; s < 832; s++) begin
      int v;
      case (kind)
        0: v = int'($urandom % 64);
        1: v = s % 64;
        default: v = 63;
      endcase
      for (int b = 0; b < 6; b++) pat[((s%8)*6+b)*104 + s/8] = v[b];
    end
  endtask

  task automatic load_all();
    int j = 0;
    while (j < NB) begin
      @(negedge clk);
      if (j == NB-1 && ser_en) chk(load_done == 0, "R3 done early", load_done, 0);
      if ($urandom % 4 == 0) begin
        ser_en = 0; ser_in = 1'($urandom);
      end else begin
        ser_en = 1; ser_in = pat[j]; j++;
      end
    end
    @(negedge clk);
    ser_en = 0;
    chk(load_done == 1, "R3 done", load_done, 1);
    for (int i = 0; i < 20; i++) begin
      ser_en = 1; ser_in = 1'($urandom);
      @(negedge clk);
    end
    ser_en = 0;
    chk(load_done == 1, "R3 done held", load_done, 1);
  endtask

  task automatic play(input int words);
    mode_play = 1;
    for (int n = 0; n < words; n++) begin
      logic [47:0] w;
      @(negedge clk);
      ser_en = 1; ser_in = 1'($urandom);
      w = exp_word(n);
      chk(out_valid == 1, "R5 valid", out_valid, 1);
      chk(samples == w, n >= 104 ? "R6 recirculate" : "R2 R5 lane order", samples, w);
      chk(therm == exp_therm(w), "R7 therm", therm, exp_therm(w));
      chk(bin == exp_bin(w), "R8 bin", bin, exp_bin(w));
    end
    mode_play = 0; ser_en = 0;
    @(negedge clk);
    chk(out_valid == 0, "R9 valid low", out_valid, 0);
    chk(therm == 0 && samples == 0 && bin == 0, "R9 outputs zero", therm, 0);
    chk(load_done == 0, "R10 done cleared", load_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(load_done == 0 && out_valid == 0, "R1 flags", {load_done, out_valid}, 0);
    chk(samples == 0 && therm == 0 && bin == 0, "R1 outputs", samples, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0 && therm == 0, "R9 load quiet", therm, 0);

    make_pat(0); load_all(); play(208);
    make_pat(1); load_all(); play(50);
    make_pat(1); load_all(); play(110);
    make_pat(2); load_all(); play(104);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule